// File: doc/BRIEF.md
# Disk Controller Phase Handshake Sequencer

This block runs the host side of a floppy-style disk controller. The host moves command bytes into a data port and later pulls result bytes out of it. A read-only status byte tells the host, at every moment, whether a byte may move through the data port and in which direction. The block steps through four phases: idle, command, execution and result. The length of each command is found by indexing a small internal table with the low five bits of the opcode.

Parameter bytes are kept in a small memory. The result phase returns a status byte first. That byte is captured from the execution engine when the command has an execution phase, is 0x00 for a command with no execution phase, and is 0x80 for an unknown opcode. The remaining result bytes echo the stored parameter bytes in order, so an execution engine or a test host can see exactly what the sequencer accepted. Media access, stepping, DMA and CRC belong to other blocks.

Top module: `dsk_phase_seq`

## Requirements
- R1: After reset the status byte is 0x80 (ready bit 7 = 1, direction bit 6 = 0, busy bit 4 = 0) with the drive inputs low, and the data read bus is 0x00.
- R2: A data-port write in idle is taken as the opcode. On the next cycle busy (bit 4) is 1. If the command has parameters, the status reads 0x90 until the last parameter byte has been written.
- R3: After the last command byte of a command with an execution phase, the status is 0x10 (ready = 0). Data-port writes and reads are then ignored until the execution-done pulse.
- R4: On execution-done in the execution phase, the status becomes 0xD0 and the input status byte is captured. Result byte 0 is that captured byte. Result byte k (k ≥ 1) is parameter byte k-1 when k-1 is below the parameter count, and 0x00 otherwise. Each byte appears on the read bus the cycle after its data-port read. After the last one, the status returns to 0x80.
- R5: Commands with no result phase return the status to 0x80 (busy clear) the cycle after their last command byte. These are specify 0x03 (2 parameters), recalibrate 0x07 (1), seek 0x0F (2) and configure 0x13 (3).
- R6: Commands with results but no execution phase go straight to result status 0xD0 with result byte 0 = 0x00. These are sense-drive 0x04 (1 parameter, 1 result) and sense-interrupt 0x08 (0 parameters, 2 results).
- R7: Any opcode not listed in R5, R6 or R10 is invalid. It goes straight to 0xD0 with a single result byte 0x80.
- R8: Status bits 1:0 show the per-drive seek-active inputs one cycle later. Bits 5, 3 and 2 are always 0.
- R9: Reading the status address changes nothing. A data-port read outside the result phase leaves the read bus unchanged, and a data-port write during the result phase is ignored. An execution-done pulse outside the execution phase is ignored.
- R10: Only opcode bits 4:0 select the table entry, so bits 7:5 have no effect. Commands with an execution phase are write 0x05 and read 0x06 (8 parameters, 7 results each) and read-id 0x0A (1 parameter, 7 results).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 1 | 0 selects the status byte, 1 selects the data port |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| drv_seek | input | 2 | Per-drive seek-active flags |
| exec_done | input | 1 | Execution-phase completion pulse |
| exec_stat | input | 8 | Status byte captured at execution completion |
| status | output | 8 | Main status byte |
| rd_data | output | 8 | Data-port read bus |

## Verification
A wrong phase or counter inside the sequencer shows on the status byte the cycle after the host strobe that caused it. Typical symptoms are ready dropping early, busy clearing one byte too soon, or direction staying low after execution-done. A wrong parameter store or result index shows in the echoed result bytes, on the first read that follows. The sweep covers every low-five-bit opcode under every value of the top three bits, so each length-table entry and each path out of the command phase is exercised.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int DSK_PAR_MAX = 8;
  localparam int DSK_CW      = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_t;

  typedef struct packed {
    logic              valid;
    logic              has_exec;
    logic [DSK_CW-1:0] n_par;
    logic [DSK_CW-1:0] n_res;
  } cmd_info_t;
endpackage

// File: rtl/dsk_cmd_decode.sv
module dsk_cmd_decode
  import dsk_pkg::*;
(
  input  logic [4:0] code,
  output cmd_info_t  info
);
  always_comb begin
    case (code)
      5'h03:   info = '{valid: 1'b1, has_exec: 1'b0, n_par: 4'd2, n_res: 4'd0};
      5'h04:   info = '{valid: 1'b1, has_exec: 1'b0, n_par: 4'd1, n_res: 4'd1};
      5'h05:   info = '{valid: 1'b1, has_exec: 1'b1, n_par: 4'd8, n_res: 4'd7};
      5'h06:   info = '{valid: 1'b1, has_exec: 1'b1, n_par: 4'd8, n_res: 4'd7};
      5'h07:   info = '{valid: 1'b1, has_exec: 1'b0, n_par: 4'd1, n_res: 4'd0};
      5'h08:   info = '{valid: 1'b1, has_exec: 1'b0, n_par: 4'd0, n_res: 4'd2};
      5'h0A:   info = '{valid: 1'b1, has_exec: 1'b1, n_par: 4'd1, n_res: 4'd7};
      5'h0F:   info = '{valid: 1'b1, has_exec: 1'b0, n_par: 4'd2, n_res: 4'd0};
      5'h13:   info = '{valid: 1'b1, has_exec: 1'b0, n_par: 4'd3, n_res: 4'd0};
      default: info = '{valid: 1'b0, has_exec: 1'b0, n_par: 4'd0, n_res: 4'd1};
    endcase
  end
endmodule

// File: rtl/dsk_param_store.sv
module dsk_param_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dsk_phase_fsm.sv
module dsk_phase_fsm
  import dsk_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DRIVES = 2,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DW-1:0]     wdata,
  input  cmd_info_t         dec_info,
  input  logic              exec_done,
  input  logic [DW-1:0]     exec_stat,
  input  logic [DRIVES-1:0] drv_seek,
  output logic              pw_en,
  output logic [AW-1:0]     pw_addr,
  output logic [AW-1:0]     pr_addr,
  input  logic [DW-1:0]     pr_data,
  output logic [DW-1:0]     status,
  output logic [DW-1:0]     rd_data
);
  phase_t            phase;
  cmd_info_t         info_q;
  logic [DSK_CW-1:0] par_cnt;
  logic [DSK_CW-1:0] res_idx;
  logic [DSK_CW-1:0] res_m1;
  logic [DW-1:0]     stat_q;
  logic [DW-1:0]     rd_q;
  logic [DRIVES-1:0] drv_q;
  logic [DW-1:0]     res_byte;

  function automatic phase_t after_params(input cmd_info_t ci);
    if (ci.has_exec)           return PH_EXEC;
    else if (ci.n_res != '0)   return PH_RES;
    else                       return PH_IDLE;
  endfunction

  assign pw_en   = wr_req && (phase == PH_CMD);
  assign pw_addr = par_cnt[AW-1:0];
  assign res_m1  = res_idx - 1'b1;
  assign pr_addr = res_m1[AW-1:0];

  always_comb begin
    if (res_idx == '0)                         res_byte = stat_q;
    else if (info_q.valid && res_m1 < info_q.n_par) res_byte = pr_data;
    else                                       res_byte = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      info_q  <= '0;
      par_cnt <= '0;
      res_idx <= '0;
      stat_q  <= '0;
      rd_q    <= '0;
      drv_q   <= '0;
    end else begin
      drv_q <= drv_seek;
      case (phase)
        PH_IDLE: if (wr_req) begin
          info_q  <= dec_info;
          par_cnt <= '0;
          res_idx <= '0;
          stat_q  <= dec_info.valid ? '0 : 8'h80;
          phase   <= (dec_info.n_par != '0) ? PH_CMD : after_params(dec_info);
        end
        PH_CMD: if (wr_req) begin
          par_cnt <= par_cnt + 1'b1;
          if (par_cnt + 1'b1 == info_q.n_par) phase <= after_params(info_q);
        end
        PH_EXEC: if (exec_done) begin
          stat_q <= exec_stat;
          phase  <= (info_q.n_res != '0) ? PH_RES : PH_IDLE;
        end
        PH_RES: if (rd_req) begin
          rd_q    <= res_byte;
          res_idx <= res_idx + 1'b1;
          if (res_idx + 1'b1 == info_q.n_res) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign status = {phase != PH_EXEC, phase == PH_RES, 1'b0, phase != PH_IDLE,
                   2'b00, drv_q};
  assign rd_data = rd_q;

  // R2: opcode accepted in idle raises busy on the next cycle
  a_r2_busy_after_opcode: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && wr_req) |=> status[4]);

  // R3: execution phase is only entered on an accepted command byte
  a_r3_exec_entry: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && $past(phase) != PH_EXEC) |-> $past(wr_req));

  // R4: execution-done leads to read-direction ready
  a_r4_done_to_result: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && exec_done) |=> (status[7:6] == 2'b11));

  // R4: result index never passes the result count
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RES) |-> (res_idx < info_q.n_res));

  // R5: busy only falls on a host data transfer
  a_r5_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(status[4]) |-> $past(wr_req || rd_req));
endmodule

// File: rtl/dsk_phase_seq.sv
module dsk_phase_seq
  import dsk_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DRIVES    = 2,
  parameter int PAR_DEPTH = DSK_PAR_MAX,
  localparam int AW       = $clog2(PAR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic [DRIVES-1:0] drv_seek,
  input  logic              exec_done,
  input  logic [DW-1:0]     exec_stat,
  output logic [DW-1:0]     status,
  output logic [DW-1:0]     rd_data
);
  logic          wr_req, rd_req, pw_en;
  logic [AW-1:0] pw_addr, pr_addr;
  logic [DW-1:0] pr_data;
  cmd_info_t     dec_info;

  assign wr_req = host_wr && host_addr;
  assign rd_req = host_rd && host_addr;

  dsk_cmd_decode u_dec (
    .code (host_wdata[4:0]),
    .info (dec_info)
  );

  dsk_param_store #(.DEPTH(PAR_DEPTH), .WIDTH(DW)) u_par (
    .clk   (clk),
    .we    (pw_en),
    .waddr (pw_addr),
    .wdata (host_wdata),
    .raddr (pr_addr),
    .rdata (pr_data)
  );

  dsk_phase_fsm #(.DW(DW), .DRIVES(DRIVES), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .wdata     (host_wdata),
    .dec_info  (dec_info),
    .exec_done (exec_done),
    .exec_stat (exec_stat),
    .drv_seek  (drv_seek),
    .pw_en     (pw_en),
    .pw_addr   (pw_addr),
    .pr_addr   (pr_addr),
    .pr_data   (pr_data),
    .status    (status),
    .rd_data   (rd_data)
  );

  // R9: a status-address read alone leaves the phase bits untouched
  a_r9_status_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_addr && !host_wr && !exec_done) |=>
      (status[7:4] == $past(status[7:4])));

  // R9: the read bus only moves on a data-port read
  a_r9_rd_bus_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));
endmodule

// File: tb/dsk_phase_seq_bench.sv
module dsk_phase_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_addr = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [1:0] drv_seek = '0;
  logic       exec_done = 1'b0;
  logic [7:0] exec_stat = '0;
  logic [7:0] status, rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  dsk_phase_seq u_dsk_phase_seq (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .drv_seek(drv_seek),
    .exec_done(exec_done), .exec_stat(exec_stat),
    .status(status), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic pulse_done(input logic [7:0] s);
    @(negedge clk);
    exec_done = 1'b1; exec_stat = s;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  // expected table: {valid, exec, n_par[3:0], n_res[3:0]} (R5 R6 R7 R10)
  function automatic logic [9:0] tbl(input logic [4:0] lo);
    case (lo)
      5'h03: return {2'b10, 4'd2, 4'd0};
      5'h04: return {2'b10, 4'd1, 4'd1};
      5'h05: return {2'b11, 4'd8, 4'd7};
      5'h06: return {2'b11, 4'd8, 4'd7};
      5'h07: return {2'b10, 4'd1, 4'd0};
      5'h08: return {2'b10, 4'd0, 4'd2};
      5'h0A: return {2'b11, 4'd1, 4'd7};
      5'h0F: return {2'b10, 4'd2, 4'd0};
      5'h13: return {2'b10, 4'd3, 4'd0};
      default: return {2'b00, 4'd0, 4'd1};
    endcase
  endfunction

  function automatic logic [7:0] pval(input int op, input int i);
    return 8'((op * 7 + i * 13 + 1) & 255);
  endfunction

  task automatic run_cmd(input int op);
    logic [9:0] e;
    logic       valid, ex;
    int         np, nr;
    logic [7:0] st0, last_rd, exp_rd;
    e = tbl(op[4:0]);
    valid = e[9]; ex = e[8]; np = int'(e[7:4]); nr = int'(e[3:0]);
    bus(1'b1, 1'b1, 1'b0, 8'(op));
    for (int i = 0; i < np; i++) begin
      chk("R2 command phase status", status, 8'h90);
      if (i == 0) begin
        bus(1'b0, 1'b0, 1'b1, 8'h00);
        chk("R9 status read quiet", status, 8'h90);
      end
      bus(1'b1, 1'b1, 1'b0, pval(op, i));
    end
    if (ex) begin
      chk("R3 execution status", status, 8'h10);
      last_rd = rd_data;
      bus(1'b1, 1'b1, 1'b0, 8'hEE);
      bus(1'b1, 1'b0, 1'b1, 8'h00);
      chk("R3 exec ignores data port", status, 8'h10);
      chk("R3 exec read bus held", rd_data, last_rd);
      st0 = 8'(op) ^ 8'h5A;
      pulse_done(st0);
    end else begin
      st0 = valid ? 8'h00 : 8'h80;
    end
    if (nr == 0) begin
      chk("R5 no result phase idle", status, 8'h80);
      return;
    end
    chk(valid ? (ex ? "R4 result status" : "R6 direct result status")
              : "R7 invalid result status", status, 8'hD0);
    for (int k = 0; k < nr; k++) begin
      if (k == 1) begin
        bus(1'b1, 1'b1, 1'b0, 8'h33);
        chk("R9 result write ignored", status, 8'hD0);
      end
      bus(1'b1, 1'b0, 1'b1, 8'h00);
      if (k == 0)        exp_rd = st0;
      else if (k - 1 < np) exp_rd = pval(op, k - 1);
      else               exp_rd = 8'h00;
      chk(valid ? "R4 result byte" : "R7 invalid byte", rd_data, exp_rd);
      chk("R4 status after read", status, (k == nr - 1) ? 8'h80 : 8'hD0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset read bus", rd_data, 8'h00);

    // R8: drive bits and reserved zeros
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      drv_seek = 2'(v);
      @(negedge clk);
      chk("R8 drive busy bits", status, 8'h80 | 8'(v));
    end
    drv_seek = 2'b00;
    @(negedge clk);

    // R9: stray execution-done and data read in idle
    pulse_done(8'h11);
    chk("R9 stray done ignored", status, 8'h80);
    bus(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R9 idle read bus held", rd_data, 8'h00);

    // R10: every opcode low field under every upper-bit prefix
    for (int hi = 0; hi < 8; hi++)
      for (int lo = 0; lo < 32; lo++)
        run_cmd(hi * 32 + lo);

    // R8 during a command
    bus(1'b1, 1'b1, 1'b0, 8'h0F);
    @(negedge clk);
    drv_seek = 2'b10;
    @(negedge clk);
    chk("R8 drive bits in command", status, 8'h92);
    drv_seek = 2'b00;
    bus(1'b1, 1'b1, 1'b0, 8'h00);
    bus(1'b1, 1'b1, 1'b0, 8'h00);
    chk("R5 seek done", status, 8'h80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule